// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a single-clock static memory whose read and write commands can follow one another on every cycle with no idle cycle between them. The word is split into byte lanes of nine bits. Address, chip selects, the load/continue control, the read/write control and the active-low lane write enables are all taken on the rising clock edge. A write supplies its address on one edge and its data on the next enabled edge. A read presents its data in the cycle after its address edge. Read data and late write data therefore use the same bus slot, and the bus never has to turn around. A two-bit burst counter lets a command continue across four neighbouring words, in either linear or XOR order.

Control is held in a three-state machine. DESEL is the idle and deselected state. READ drives the bus. WRITE expects data on the next edge. The machine moves on the next enabled edge as follows. A load with the chip selected and read requested goes to READ (load-read). A load with the chip selected and write requested goes to WRITE (load-write). A load with the chip not selected goes to DESEL (load-deselect). A continue cycle keeps the current state (continue). An edge with the clock enable off, or taken while snooze is high, changes nothing (stall).

Write data first waits in a pending-write register and moves into the array on the next enabled edge. A read of that address meanwhile takes the newest data from the register lane by lane. The data bus is modelled as separate in and out ports plus an enable flag. The depth is set by a parameter.

Top module: `zt_sram`

## Requirements
- R1: A cycle type is chosen only on a load edge (adv_ld_n low): rd_wr_n high starts a read and rd_wr_n low starts a write. On a continue edge (adv_ld_n high) rd_wr_n is ignored and the burst keeps the type of the last load.
- R2: A write takes its address and lane enables on its load or continue edge. It takes its data from din on the next enabled edge.
- R3: Lane i of the word is bits [9i+8:9i], and it is written only when bwe_n[i] is low on the command edge. Any subset of lanes may be written. A write with all of bwe_n high leaves the array unchanged and keeps dout_en low.
- R4: The burst counter starts at zero on a load and advances by one on every enabled continue edge. After the fourth access it wraps back to the starting address.
- R5: The effective address keeps the upper address bits of the load. Its two low bits are (base + k) mod 4 when burst_il is 0, and base XOR k when burst_il is 1, where k is the counter value.
- R6: The chip is selected on a load only when cs_n is 0, cs2_n is 0 and cs2 is 1. Any other combination on a load deselects it, with dout_en low. Continue edges after a deselect keep it deselected.
- R7: An edge with clk_en_n high changes no state and writes nothing. A read keeps driving the same data, and a write keeps the bus off and still waits for its data.
- R8: A read of a word whose write data is still in the pending-write register returns that newest data in the written lanes and array data in the other lanes.
- R9: dout_en is high only in a read cycle with oe_n low. During write cycles dout_en stays low whatever oe_n is. oe_n acts without waiting for a clock edge. dout is all zeros whenever dout_en is low.
- R10: While snooze is high, dout_en is low and every clock edge except a reset edge is ignored. The array and the state are kept, and a read in progress resumes once snooze falls.
- R11: A read's data for a load or continue edge appears on dout in the cycle right after that edge.
- R12: A reset edge (rst high) returns the block to the deselected state with no write pending and dout_en low. Write data that would have been taken on that edge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high turns the edge into a stall |
| snooze | input | 1 | Asynchronous low-power hold, active high |
| cs_n | input | 1 | Chip select, active low, sampled on load |
| cs2_n | input | 1 | Second chip select, active low, sampled on load |
| cs2 | input | 1 | Third chip select, active high, sampled on load |
| adv_ld_n | input | 1 | Low: load a new command; high: continue the burst |
| rd_wr_n | input | 1 | High read, low write; used on load edges only |
| bwe_n | input | LANES | Lane write enables, active low |
| addr | input | ADDR_W | Word address |
| burst_il | input | 1 | Burst order: 0 linear, 1 XOR; held static in use |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data, taken one enabled edge after the command |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | High when dout is driven |

## Verification
The bench builds the core with ADDR_W = 6 and the default four lanes of nine bits. With 64 words the bench can fill the whole array with known data before any read, so every read is compared against a full reference copy. Bursts based at each low-address value, including the wrap from the last word of a group back to its base, fit in a short table walk. The narrow address also makes forwarding hits and burst overlaps between neighbouring commands common rather than rare.

// File: rtl/zt_pkg.sv
package zt_pkg;
    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } zt_state_e;

    localparam int unsigned BURST_W = 2;
endpackage

// File: rtl/zt_ctrl.sv
module zt_ctrl
    import zt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      edge_en,
    input  logic      load,
    input  logic      chip_sel,
    input  logic      rd_req,
    input  logic      oe_n,
    input  logic      snooze,
    output zt_state_e state_q,
    output logic      drive_en,
    output logic      wr_phase
);
    zt_state_e state_d;
    zt_state_e load_tgt;

    // Target of a load edge: selection first, then cycle type.
    always_comb begin
        if (!chip_sel) begin
            load_tgt = ST_DESEL;
        end else if (rd_req) begin
            load_tgt = ST_READ;
        end else begin
            load_tgt = ST_WRITE;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DESEL: begin
                // load-read / load-write / load-deselect; continue keeps DESEL
                if (edge_en && load) state_d = load_tgt;
            end
            ST_READ: begin
                // continue keeps READ, rd_req ignored
                if (edge_en && load) state_d = load_tgt;
            end
            ST_WRITE: begin
                // continue keeps WRITE, rd_req ignored
                if (edge_en && load) state_d = load_tgt;
            end
            default: state_d = ST_DESEL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DESEL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        drive_en = 1'b0;
        wr_phase = 1'b0;
        unique case (state_q)
            ST_DESEL: begin
                drive_en = 1'b0;
            end
            ST_READ: begin
                drive_en = !oe_n && !snooze;
            end
            ST_WRITE: begin
                wr_phase = 1'b1;
            end
            default: begin
                drive_en = 1'b0;
            end
        endcase
    end

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !edge_en |=> $stable(state_q));
    p_cont_keep_r1: assert property (@(posedge clk) disable iff (rst)
        (edge_en && !load) |=> $stable(state_q));
    p_desel_r6: assert property (@(posedge clk) disable iff (rst)
        (edge_en && load && !chip_sel) |=> (state_q == ST_DESEL));
    p_reset_r12: assert property (@(posedge clk)
        rst |=> (state_q == ST_DESEL));
    p_wr_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WRITE) |-> !drive_en);
    p_snooze_off_r10: assert property (@(posedge clk) disable iff (rst)
        snooze |-> !drive_en);
endmodule

// File: rtl/zt_burst.sv
module zt_burst
    import zt_pkg::*;
#(
    parameter int unsigned ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              edge_en,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              interleave,
    output logic [ADDR_W-1:0] addr_eff
);
    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] low_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (edge_en) begin
            if (load) begin
                base_q <= addr_in;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        if (interleave) begin
            low_bits = base_q[BURST_W-1:0] ^ cnt_q;
        end else begin
            low_bits = base_q[BURST_W-1:0] + cnt_q;
        end
        addr_eff = {base_q[ADDR_W-1:BURST_W], low_bits};
    end

    p_load_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (edge_en && load) |=> (cnt_q == '0));
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (edge_en && !load) |=> (cnt_q == BURST_W'($past(cnt_q) + 1'b1)));
    p_base_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (edge_en && !load) |=> $stable(base_q));
    p_stall_cnt_r7: assert property (@(posedge clk) disable iff (rst)
        !edge_en |=> ($stable(cnt_q) && $stable(base_q)));
endmodule

// File: rtl/zt_wbuf.sv
module zt_wbuf #(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     edge_en,
    input  logic                     capture,
    input  logic [ADDR_W-1:0]        cap_addr,
    input  logic [LANES-1:0]         cap_lanes,
    input  logic [LANES*LANE_W-1:0]  cap_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [LANES*LANE_W-1:0]  mem_data,
    output logic                     pend_valid,
    output logic [ADDR_W-1:0]        pend_addr,
    output logic [LANES-1:0]         pend_lanes,
    output logic [LANES*LANE_W-1:0]  pend_data,
    output logic [LANES*LANE_W-1:0]  fwd_data
);
    logic hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_lanes <= '0;
            pend_data  <= '0;
        end else if (edge_en) begin
            pend_valid <= capture;
            if (capture) begin
                pend_addr  <= cap_addr;
                pend_lanes <= cap_lanes;
                pend_data  <= cap_data;
            end
        end
    end

    assign hit = pend_valid && (pend_addr == rd_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_fwd
        assign fwd_data[l*LANE_W +: LANE_W] = (hit && pend_lanes[l])
            ? pend_data[l*LANE_W +: LANE_W]
            : mem_data[l*LANE_W +: LANE_W];
    end

    p_abort_r3: assert property (@(posedge clk) disable iff (rst)
        (edge_en && !capture) |=> !pend_valid);
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (edge_en && capture) |=> (pend_valid && (pend_addr == $past(cap_addr))));
    p_pend_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !edge_en |=> ($stable(pend_valid) && $stable(pend_data)));
    p_reset_pend_r12: assert property (@(posedge clk)
        rst |=> !pend_valid);
endmodule

// File: rtl/zt_array.sv
module zt_array #(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[l]) begin
                lane_mem[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
            end
        end

        assign rd_data[l*LANE_W +: LANE_W] = lane_mem[rd_addr];
    end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clk_en_n,
    input  logic                    snooze,
    input  logic                    cs_n,
    input  logic                    cs2_n,
    input  logic                    cs2,
    input  logic                    adv_ld_n,
    input  logic                    rd_wr_n,
    input  logic [LANES-1:0]        bwe_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    burst_il,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);
    localparam int unsigned DATA_W = LANES * LANE_W;

    zt_state_e          state_q;
    logic               edge_en;
    logic               load;
    logic               chip_sel;
    logic               drive_en;
    logic               wr_phase;
    logic               capture;
    logic [LANES-1:0]   lane_q;
    logic [ADDR_W-1:0]  addr_eff;
    logic               pend_valid;
    logic [ADDR_W-1:0]  pend_addr;
    logic [LANES-1:0]   pend_lanes;
    logic [DATA_W-1:0]  pend_data;
    logic [DATA_W-1:0]  mem_data;
    logic [DATA_W-1:0]  fwd_data;

    assign edge_en  = !clk_en_n && !snooze;
    assign load     = !adv_ld_n;
    assign chip_sel = !cs_n && !cs2_n && cs2;

    // Lane enables are taken on every command edge, load or continue.
    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q <= '0;
        end else if (edge_en) begin
            lane_q <= ~bwe_n;
        end
    end

    assign capture = wr_phase && (|lane_q);

    zt_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .edge_en  (edge_en),
        .load     (load),
        .chip_sel (chip_sel),
        .rd_req   (rd_wr_n),
        .oe_n     (oe_n),
        .snooze   (snooze),
        .state_q  (state_q),
        .drive_en (drive_en),
        .wr_phase (wr_phase)
    );

    zt_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk        (clk),
        .rst        (rst),
        .edge_en    (edge_en),
        .load       (load),
        .addr_in    (addr),
        .interleave (burst_il),
        .addr_eff   (addr_eff)
    );

    zt_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
        .clk        (clk),
        .rst        (rst),
        .edge_en    (edge_en),
        .capture    (capture),
        .cap_addr   (addr_eff),
        .cap_lanes  (lane_q),
        .cap_data   (din),
        .rd_addr    (addr_eff),
        .mem_data   (mem_data),
        .pend_valid (pend_valid),
        .pend_addr  (pend_addr),
        .pend_lanes (pend_lanes),
        .pend_data  (pend_data),
        .fwd_data   (fwd_data)
    );

    zt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk      (clk),
        .wr_en    (edge_en && pend_valid),
        .wr_addr  (pend_addr),
        .wr_lanes (pend_lanes),
        .wr_data  (pend_data),
        .rd_addr  (addr_eff),
        .rd_data  (mem_data)
    );

    assign dout_en = drive_en;
    assign dout    = drive_en ? fwd_data : '0;

    p_write_off_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WRITE) |-> !dout_en);
    p_read_after_load_r11: assert property (@(posedge clk) disable iff (rst)
        (edge_en && load && chip_sel && rd_wr_n) |=> (state_q == ST_READ));
    p_snooze_bus_r10: assert property (@(posedge clk) disable iff (rst)
        snooze |-> (dout_en == 1'b0));
endmodule

// File: tb/tb_zt_sram.sv
`timescale 1ns/1ps
module tb_zt_sram;
    localparam int AW  = 6;
    localparam int LN  = 4;
    localparam int LW  = 9;
    localparam int DW  = LN * LW;
    localparam int DEP = 1 << AW;
    localparam int NV  = 29;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en_n = 1'b0;
    logic          snooze = 1'b0;
    logic          cs_n = 1'b1;
    logic          cs2_n = 1'b0;
    logic          cs2 = 1'b1;
    logic          adv_ld_n = 1'b0;
    logic          rd_wr_n = 1'b1;
    logic [LN-1:0] bwe_n = '1;
    logic [AW-1:0] addr = '0;
    logic          burst_il = 1'b0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    always #2.5 clk = ~clk;

    zt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .snooze(snooze),
        .cs_n(cs_n), .cs2_n(cs2_n), .cs2(cs2), .adv_ld_n(adv_ld_n),
        .rd_wr_n(rd_wr_n), .bwe_n(bwe_n), .addr(addr), .burst_il(burst_il),
        .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
    );

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] ref_mem [DEP];
    int            m_st = 0;       // 0 deselected, 1 read, 2 write
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_k = '0;
    logic [LN-1:0] m_lanes = '0;
    logic [8:0]    pat = '0;
    string         prev_tag = "R12";

    // Vector: {req[3:0], adv_n, rw, selc[1:0], addr[5:0], ben[3:0], stall}
    // selc: 0 selected, 1 cs_n high, 2 cs2_n high, 3 cs2 low
    localparam logic [18:0] VEC [NV] = '{
        {4'd9,  1'b0, 1'b0, 2'd0, 6'd8,  4'h0, 1'b0}, // R9 write a8
        {4'd8,  1'b0, 1'b1, 2'd0, 6'd8,  4'h0, 1'b0}, // R8 read a8, forwarded
        {4'd3,  1'b0, 1'b0, 2'd0, 6'd9,  4'hA, 1'b0}, // R3 lanes 0,2 of a9
        {4'd8,  1'b0, 1'b1, 2'd0, 6'd9,  4'h0, 1'b0}, // R8 merged read a9
        {4'd2,  1'b0, 1'b0, 2'd0, 6'd12, 4'h0, 1'b0}, // R2 burst write 12
        {4'd4,  1'b1, 1'b0, 2'd0, 6'd0,  4'h0, 1'b0}, // R4 13
        {4'd3,  1'b1, 1'b0, 2'd0, 6'd0,  4'hE, 1'b0}, // R3 14 lane 0 only
        {4'd4,  1'b1, 1'b0, 2'd0, 6'd0,  4'h0, 1'b0}, // R4 15
        {4'd4,  1'b1, 1'b0, 2'd0, 6'd0,  4'h0, 1'b0}, // R4 wrap to 12
        {4'd4,  1'b0, 1'b1, 2'd0, 6'd13, 4'h0, 1'b0}, // R4 read burst 13
        {4'd1,  1'b1, 1'b0, 2'd0, 6'd0,  4'h0, 1'b0}, // R1 rw low ignored
        {4'd5,  1'b1, 1'b1, 2'd0, 6'd0,  4'h0, 1'b0}, // R5 linear 15
        {4'd5,  1'b1, 1'b1, 2'd0, 6'd0,  4'h0, 1'b0}, // R5 linear 12
        {4'd4,  1'b1, 1'b1, 2'd0, 6'd0,  4'h0, 1'b0}, // R4 wrap to 13
        {4'd3,  1'b0, 1'b0, 2'd0, 6'd20, 4'hF, 1'b0}, // R3 abort a20
        {4'd3,  1'b0, 1'b1, 2'd0, 6'd20, 4'h0, 1'b0}, // R3 a20 unchanged
        {4'd6,  1'b0, 1'b1, 2'd1, 6'd0,  4'h0, 1'b0}, // R6 cs_n high
        {4'd6,  1'b1, 1'b1, 2'd0, 6'd0,  4'h0, 1'b0}, // R6 continue deselect
        {4'd7,  1'b0, 1'b1, 2'd0, 6'd12, 4'h0, 1'b1}, // R7 stalled load
        {4'd11, 1'b0, 1'b1, 2'd0, 6'd14, 4'h0, 1'b0}, // R11 read a14
        {4'd7,  1'b0, 1'b0, 2'd0, 6'd33, 4'h0, 1'b1}, // R7 stall keeps read
        {4'd1,  1'b1, 1'b0, 2'd0, 6'd0,  4'h0, 1'b0}, // R1 continue a15
        {4'd9,  1'b0, 1'b0, 2'd0, 6'd30, 4'h0, 1'b0}, // R9 write a30
        {4'd7,  1'b0, 1'b1, 2'd0, 6'd0,  4'h0, 1'b1}, // R7 stall in write
        {4'd8,  1'b0, 1'b1, 2'd0, 6'd30, 4'h0, 1'b0}, // R8 read a30
        {4'd6,  1'b0, 1'b1, 2'd3, 6'd0,  4'h0, 1'b0}, // R6 cs2 low
        {4'd6,  1'b0, 1'b0, 2'd2, 6'd0,  4'h0, 1'b0}, // R6 cs2_n high
        {4'd11, 1'b0, 1'b1, 2'd0, 6'd63, 4'h0, 1'b0}, // R11 read a63
        {4'd6,  1'b0, 1'b1, 2'd1, 6'd0,  4'h0, 1'b0}  // R6 deselect
    };

    function automatic logic [AW-1:0] m_eff();
        logic [1:0] lo;
        lo = burst_il ? (m_base[1:0] ^ m_k) : (m_base[1:0] + m_k);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic check_out(input string tag);
        logic          exp_en;
        logic [DW-1:0] exp_d;
        exp_en = (m_st == 1) && !oe_n && !snooze;
        exp_d  = exp_en ? ref_mem[m_eff()] : '0;
        checks++;
        if ({dout_en, dout} !== {exp_en, exp_d}) begin
            fails++;
            $display("FAIL %s: got en=%0b data=%h, expected en=%0b data=%h",
                     tag, dout_en, dout, exp_en, exp_d);
        end
    endtask

    task automatic tick(input logic adv_n, input logic rw, input logic [1:0] selc,
                        input logic [AW-1:0] a, input logic [LN-1:0] ben,
                        input logic stall, input string tag);
        logic          en;
        logic [DW-1:0] nd;
        logic [AW-1:0] wa;
        check_out(prev_tag);
        prev_tag = tag;
        en = !stall && !snooze;
        if (en && m_st == 2) begin
            pat = pat + 9'd1;
            nd  = {pat ^ 9'h1A5, pat ^ 9'h0F0, pat + 9'd77, pat};
            din = nd;
            wa  = m_eff();
            for (int l = 0; l < LN; l++) begin
                if (m_lanes[l]) ref_mem[wa][l*LW +: LW] = nd[l*LW +: LW];
            end
        end
        clk_en_n = stall;
        adv_ld_n = adv_n;
        rd_wr_n  = rw;
        cs_n     = (selc == 2'd1);
        cs2_n    = (selc == 2'd2);
        cs2      = (selc != 2'd3);
        addr     = a;
        bwe_n    = ben;
        if (en) begin
            if (!adv_n) begin
                m_st   = (selc != 2'd0) ? 0 : (rw ? 1 : 2);
                m_base = a;
                m_k    = '0;
            end else begin
                m_k = m_k + 2'd1;
            end
            m_lanes = ~ben;
        end
        @(negedge clk);
    endtask

    initial begin
        #(100000 * 5);
        fails++;
        $display("FAIL watchdog R12: run did not end, got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        check_out("R12 reset state");
        rst = 1'b0;

        // R2: fill every word back to back
        for (int i = 0; i < DEP; i++) tick(1'b0, 1'b0, 2'd0, AW'(i), 4'h0, 1'b0, "R2");
        tick(1'b0, 1'b1, 2'd1, '0, 4'h0, 1'b0, "R6");

        // Table walk
        for (int v = 0; v < NV; v++) begin
            tick(VEC[v][14], VEC[v][13], VEC[v][12:11], VEC[v][10:5],
                 VEC[v][4:1], VEC[v][0], $sformatf("R%0d", VEC[v][18:15]));
        end

        // R5: XOR-ordered burst write from base 41, then single reads
        burst_il = 1'b1;
        tick(1'b0, 1'b0, 2'd0, 6'd41, 4'h0, 1'b0, "R5");
        for (int k = 0; k < 3; k++) tick(1'b1, 1'b0, 2'd0, '0, 4'h0, 1'b0, "R5");
        for (int k = 40; k < 44; k++) tick(1'b0, 1'b1, 2'd0, AW'(k), 4'h0, 1'b0, "R5 xor order");
        tick(1'b0, 1'b1, 2'd0, 6'd42, 4'h0, 1'b0, "R5 xor read");
        for (int k = 0; k < 4; k++) tick(1'b1, 1'b1, 2'd0, '0, 4'h0, 1'b0, "R5 xor read");
        tick(1'b0, 1'b1, 2'd1, '0, 4'h0, 1'b0, "R6");
        burst_il = 1'b0;

        // R9: oe_n gating without a clock edge
        tick(1'b0, 1'b1, 2'd0, 6'd5, 4'h0, 1'b0, "R11");
        oe_n = 1'b1; #1;
        check_out("R9 oe_n high");
        oe_n = 1'b0; #1;
        check_out("R9 oe_n low");

        // R10: snooze hides the bus and ignores edges
        snooze = 1'b1; #1;
        check_out("R10 snooze bus off");
        tick(1'b0, 1'b0, 2'd0, 6'd5, 4'h0, 1'b0, "R10 ignored write");
        tick(1'b0, 1'b1, 2'd0, 6'd7, 4'h0, 1'b0, "R10 ignored read");
        snooze = 1'b0; #1;
        check_out("R10 read resumes");
        tick(1'b0, 1'b1, 2'd0, 6'd5, 4'h0, 1'b0, "R10 array kept");
        tick(1'b0, 1'b1, 2'd1, '0, 4'h0, 1'b0, "R6");

        // R12: reset on the data edge drops the write
        tick(1'b0, 1'b0, 2'd0, 6'd6, 4'h0, 1'b0, "R9");
        check_out(prev_tag);
        din = '1;
        rst = 1'b1;
        adv_ld_n = 1'b0;
        cs_n = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_st = 0;
        m_k = '0;
        check_out("R12 after reset");
        prev_tag = "R12";
        tick(1'b0, 1'b1, 2'd0, 6'd6, 4'h0, 1'b0, "R12 write dropped");
        tick(1'b0, 1'b1, 2'd1, '0, 4'h0, 1'b0, "R6");
        check_out(prev_tag);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule